// File: doc/BRIEF.md
# Bit-Serial Rotation CORDIC Engine

This block rotates a two-dimensional vector by an angle using shift-and-add micro-rotations. All three working quantities (the two coordinates and the residual angle) are processed one bit per clock, least significant bit first. Each quantity lives in its own circulating shift register with a single full adder and a carry flip-flop. The same serial hardware handles every micro-rotation, so one iteration takes one full word of clocks. The result rate is therefore the clock frequency divided by the product of iteration count and word length. The aim is a very short critical path: one full adder, a tap multiplexer and a flip-flop.

A host places signed operands on the parallel inputs and pulses `start` while the engine is idle. The engine then runs the configured number of iterations and shows the rotated vector and the residual angle on registered outputs, together with a one-cycle `done` pulse. Both coordinates come out multiplied by the usual CORDIC gain of about 1.647. That gain is not compensated, and only rotation (not vectoring) is performed. Angles are signed fixed point with 13 fractional bits of radians at the default 16-bit word.

Top module: `serial_cordic_rot`

## Requirements
- R1: While `rst` is high and after it falls, until the first operation, `done` and `busy` are 0 and `x_out`, `y_out` and `z_out` are 0.
- R2: A `start` seen at a rising edge while `busy` is 0 captures `x_in`, `y_in` and `z_in`. `busy` is 1 from the next cycle, and later changes on the operand inputs have no effect on that operation.
- R3: `done` is a single-cycle pulse. It rises exactly ITER×WORD (224 by default) rising edges after the edge that captured `start`, and on that same edge `busy` returns to 0.
- R4: The outputs equal ITER steps i = 0..ITER-1 of the following recurrence, all in WORD-bit two's complement with wrap-around. When z has its sign bit clear: x ← x − (y>>>i), y ← y + (x>>>i), z ← z − A[i]. When the sign bit is set, each of the three signs is reversed.
- R5: The shift y>>>i and x>>>i is an arithmetic right shift: once a bit position runs past the MSB, the sign bit is repeated. Negative coordinates and shifts up to 13 must follow this.
- R6: The angle constants are A[i] = round(atan(2^-i)·2^13) for a 16-bit word: 6434, 3798, 2007, 1019, 511, 256, 128, 64, 32, 16, 8, 4, 2, 1 for i = 0..13.
- R7: A `start` pulse while `busy` is 1 is ignored. The running result and the timing of its `done` are unchanged.
- R8: Between `done` pulses, `x_out`, `y_out` and `z_out` hold their last value.
- R9: A residual angle of exactly zero counts as non-negative. That iteration subtracts y>>>i from x and subtracts A[i] from z.
- R10: A new `start` may be given on the cycle right after `done`, and it is accepted and computed correctly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation (accepted only when idle) |
| x_in | input | WORD | Initial x coordinate, signed |
| y_in | input | WORD | Initial y coordinate, signed |
| z_in | input | WORD | Rotation angle, signed, 13 fractional bits of radians |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse when results are updated |
| x_out | output | WORD | Rotated x coordinate (gain not removed) |
| y_out | output | WORD | Rotated y coordinate (gain not removed) |
| z_out | output | WORD | Residual angle |

## Verification
The directed scenarios use negative coordinates and large shift amounts, so the tapped bit runs past the MSB. A tap that wraps around or repeats zero instead of the sign bit ends up with wrong low-order coordinates. Operands near full scale force wrap-around, which exposes a carry flip-flop that is not re-seeded at each word boundary, because stale carries corrupt every later iteration. A zero starting angle checks the direction decision at the boundary. A start pulse injected mid-run must leave both the result and the 224-cycle latency of `done` unchanged. A back-to-back start and a hold interval after `done` catch a controller that drops the request or a result register that keeps updating.

// File: rtl/scr_pkg.sv
`timescale 1ns/1ps
package scr_pkg;

  // Elementary angles atan(2^-i) in radians, 13 fractional bits (16-bit word).
  function automatic logic [15:0] base_angle(input int idx);
    case (idx)
      0:  base_angle = 16'd6434;
      1:  base_angle = 16'd3798;
      2:  base_angle = 16'd2007;
      3:  base_angle = 16'd1019;
      4:  base_angle = 16'd511;
      5:  base_angle = 16'd256;
      6:  base_angle = 16'd128;
      7:  base_angle = 16'd64;
      8:  base_angle = 16'd32;
      9:  base_angle = 16'd16;
      10: base_angle = 16'd8;
      11: base_angle = 16'd4;
      12: base_angle = 16'd2;
      13: base_angle = 16'd1;
      default: base_angle = 16'd0;
    endcase
  endfunction

endpackage

// File: rtl/scr_ctrl.sv
`timescale 1ns/1ps
module scr_ctrl #(
  parameter int WORD = 16,
  parameter int ITER = 14,
  localparam int KW = $clog2(WORD),
  localparam int IW = (ITER > 1) ? $clog2(ITER) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  output logic          load,
  output logic          run,
  output logic          first_bit,
  output logic          last_step,
  output logic [KW-1:0] bit_idx,
  output logic [IW-1:0] iter_idx
);

  localparam logic [KW-1:0] BIT_LAST  = KW'(WORD - 1);
  localparam logic [IW-1:0] ITER_LAST = IW'(ITER - 1);

  logic          run_q;
  logic [KW-1:0] k_q;
  logic [IW-1:0] it_q;

  assign load      = start && !run_q;
  assign run       = run_q;
  assign first_bit = run_q && (k_q == '0);
  assign last_step = run_q && (k_q == BIT_LAST) && (it_q == ITER_LAST);
  assign bit_idx   = k_q;
  assign iter_idx  = it_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= 1'b0;
      k_q   <= '0;
      it_q  <= '0;
    end else if (load) begin
      run_q <= 1'b1;
      k_q   <= '0;
      it_q  <= '0;
    end else if (run_q) begin
      if (k_q == BIT_LAST) begin
        k_q <= '0;
        if (it_q == ITER_LAST) begin
          run_q <= 1'b0;
          it_q  <= '0;
        end else begin
          it_q <= it_q + 1'b1;
        end
      end else begin
        k_q <= k_q + 1'b1;
      end
    end
  end

endmodule

// File: rtl/scr_lane.sv
`timescale 1ns/1ps
// One serial branch: circulating word register, full adder, carry flop,
// and a held copy of the word's sign bit for the shifted tap.
module scr_lane #(
  parameter int WORD = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load,
  input  logic            run,
  input  logic            first_bit,
  input  logic [WORD-1:0] load_word,
  input  logic            b_bit,
  input  logic            sub,
  output logic [WORD-1:0] word,
  output logic            sign_hold,
  output logic [WORD-1:0] next_word
);

  logic carry_q;
  logic c_in, b_eff, sum_bit, c_out;

  always_comb begin
    b_eff     = b_bit ^ sub;
    c_in      = first_bit ? sub : carry_q;
    sum_bit   = word[0] ^ b_eff ^ c_in;
    c_out     = (word[0] & b_eff) | (word[0] & c_in) | (b_eff & c_in);
    next_word = {sum_bit, word[WORD-1:1]};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      word      <= '0;
      carry_q   <= 1'b0;
      sign_hold <= 1'b0;
    end else if (load) begin
      word    <= load_word;
      carry_q <= 1'b0;
    end else if (run) begin
      word    <= next_word;
      carry_q <= c_out;
      if (first_bit) sign_hold <= word[WORD-1];
    end
  end

endmodule

// File: rtl/scr_tap.sv
`timescale 1ns/1ps
// Picks bit (bit_idx + shift) of the word being consumed; past the MSB the
// held sign bit is repeated.
module scr_tap #(
  parameter int WORD = 16,
  parameter int ITER = 14,
  localparam int KW = $clog2(WORD),
  localparam int IW = (ITER > 1) ? $clog2(ITER) : 1
) (
  input  logic [WORD-1:0] word,
  input  logic            sign_hold,
  input  logic [KW-1:0]   bit_idx,
  input  logic [IW-1:0]   shift_amt,
  output logic            tap_bit
);

  always_comb begin
    if ((int'(bit_idx) + int'(shift_amt)) < WORD)
      tap_bit = word[int'(shift_amt)];
    else
      tap_bit = sign_hold;
  end

endmodule

// File: rtl/scr_angle_rom.sv
`timescale 1ns/1ps
module scr_angle_rom #(
  parameter int WORD = 16,
  parameter int ITER = 14,
  localparam int KW = $clog2(WORD),
  localparam int IW = (ITER > 1) ? $clog2(ITER) : 1
) (
  input  logic [IW-1:0] iter_idx,
  input  logic [KW-1:0] bit_idx,
  output logic          ang_bit
);
  import scr_pkg::*;

  logic [WORD-1:0] table_q [ITER];

  for (genvar g = 0; g < ITER; g++) begin : g_tab
    assign table_q[g] = WORD'(base_angle(g)) << (WORD - 16);
  end

  assign ang_bit = table_q[iter_idx][bit_idx];

endmodule

// File: rtl/serial_cordic_rot.sv
`timescale 1ns/1ps
module serial_cordic_rot #(
  parameter int WORD = 16,
  parameter int ITER = 14,
  localparam int KW = $clog2(WORD),
  localparam int IW = (ITER > 1) ? $clog2(ITER) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [WORD-1:0] x_in,
  input  logic [WORD-1:0] y_in,
  input  logic [WORD-1:0] z_in,
  output logic            busy,
  output logic            done,
  output logic [WORD-1:0] x_out,
  output logic [WORD-1:0] y_out,
  output logic [WORD-1:0] z_out
);

  logic          load, run, first_bit, last_step;
  logic [KW-1:0] bit_idx;
  logic [IW-1:0] iter_idx;

  logic [WORD-1:0] x_w, y_w, z_w, x_nx, y_nx, z_nx;
  logic            x_sg, y_sg, z_sg;
  logic            x_tap, y_tap, ang_bit, neg;

  scr_ctrl #(.WORD(WORD), .ITER(ITER)) ctrl_i (
    .clk(clk), .rst(rst), .start(start), .load(load), .run(run),
    .first_bit(first_bit), .last_step(last_step),
    .bit_idx(bit_idx), .iter_idx(iter_idx)
  );

  // Direction: sign of z at the word boundary, then held for the word.
  assign neg = first_bit ? z_w[WORD-1] : z_sg;

  scr_tap #(.WORD(WORD), .ITER(ITER)) tap_x_i (
    .word(x_w), .sign_hold(x_sg), .bit_idx(bit_idx),
    .shift_amt(iter_idx), .tap_bit(x_tap)
  );

  scr_tap #(.WORD(WORD), .ITER(ITER)) tap_y_i (
    .word(y_w), .sign_hold(y_sg), .bit_idx(bit_idx),
    .shift_amt(iter_idx), .tap_bit(y_tap)
  );

  scr_angle_rom #(.WORD(WORD), .ITER(ITER)) rom_i (
    .iter_idx(iter_idx), .bit_idx(bit_idx), .ang_bit(ang_bit)
  );

  scr_lane #(.WORD(WORD)) lane_x_i (
    .clk(clk), .rst(rst), .load(load), .run(run), .first_bit(first_bit),
    .load_word(x_in), .b_bit(y_tap), .sub(~neg),
    .word(x_w), .sign_hold(x_sg), .next_word(x_nx)
  );

  scr_lane #(.WORD(WORD)) lane_y_i (
    .clk(clk), .rst(rst), .load(load), .run(run), .first_bit(first_bit),
    .load_word(y_in), .b_bit(x_tap), .sub(neg),
    .word(y_w), .sign_hold(y_sg), .next_word(y_nx)
  );

  scr_lane #(.WORD(WORD)) lane_z_i (
    .clk(clk), .rst(rst), .load(load), .run(run), .first_bit(first_bit),
    .load_word(z_in), .b_bit(ang_bit), .sub(~neg),
    .word(z_w), .sign_hold(z_sg), .next_word(z_nx)
  );

  assign busy = run;

  always_ff @(posedge clk) begin
    if (rst) begin
      done  <= 1'b0;
      x_out <= '0;
      y_out <= '0;
      z_out <= '0;
    end else begin
      done <= last_step;
      if (last_step) begin
        x_out <= x_nx;
        y_out <= y_nx;
        z_out <= z_nx;
      end
    end
  end

endmodule

// File: rtl/serial_cordic_rot_chk.sv
`timescale 1ns/1ps
module serial_cordic_rot_chk #(
  parameter int WORD = 16,
  parameter int ITER = 14
) (
  input logic            clk,
  input logic            rst,
  input logic            start,
  input logic            busy,
  input logic            done,
  input logic [WORD-1:0] x_out,
  input logic [WORD-1:0] y_out,
  input logic [WORD-1:0] z_out
);

  int busy_cnt;

  always_ff @(posedge clk) begin
    if (rst) busy_cnt <= 0;
    else     busy_cnt <= busy ? busy_cnt + 1 : 0;
  end

  p_start_busy_r2: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy);

  p_done_pulse_r3: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_busy_end_r3: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);

  p_latency_r3: assert property (@(posedge clk) disable iff (rst)
    done |-> (busy_cnt == ITER * WORD));

  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !done |-> ($stable(x_out) && $stable(y_out) && $stable(z_out)));

endmodule

bind serial_cordic_rot serial_cordic_rot_chk #(.WORD(WORD), .ITER(ITER)) chk_i (
  .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
  .x_out(x_out), .y_out(y_out), .z_out(z_out)
);

// File: tb/serial_cordic_rot_tb_top.sv
`timescale 1ns/1ps
module serial_cordic_rot_tb_top;

  localparam int WORD = 16;
  localparam int ITER = 14;
  localparam int LAT  = WORD * ITER;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [WORD-1:0] x_in = '0, y_in = '0, z_in = '0;
  logic busy, done;
  logic [WORD-1:0] x_out, y_out, z_out;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  serial_cordic_rot #(.WORD(WORD), .ITER(ITER)) dut_i (
    .clk(clk), .rst(rst), .start(start), .x_in(x_in), .y_in(y_in),
    .z_in(z_in), .busy(busy), .done(done),
    .x_out(x_out), .y_out(y_out), .z_out(z_out)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Reference recurrence from R4/R5/R6/R9.
  function automatic void model(input logic signed [15:0] xi, yi, zi,
                                output logic [15:0] xo, yo, zo);
    logic signed [15:0] ang [14] = '{16'sd6434, 16'sd3798, 16'sd2007,
      16'sd1019, 16'sd511, 16'sd256, 16'sd128, 16'sd64, 16'sd32, 16'sd16,
      16'sd8, 16'sd4, 16'sd2, 16'sd1};
    logic signed [15:0] x = xi, y = yi, z = zi, xn, yn;
    for (int i = 0; i < ITER; i++) begin
      if (z[15] == 1'b0) begin
        xn = x - (y >>> i); yn = y + (x >>> i); z = z - ang[i];
      end else begin
        xn = x + (y >>> i); yn = y - (x >>> i); z = z + ang[i];
      end
      x = xn; y = yn;
    end
    xo = x; yo = y; zo = z;
  endfunction

  task automatic run_op(input string req, input logic [15:0] xi, yi, zi,
                        input bit inject);
    logic [15:0] ex, ey, ez;
    model(xi, yi, zi, ex, ey, ez);
    @(negedge clk);
    x_in = xi; y_in = yi; z_in = zi; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R2", "busy after start", 32'(busy), 32'd1);
    x_in = 16'h5a5a; y_in = 16'ha5a5; z_in = 16'h1111;   // R2: no effect
    for (int c = 1; c <= LAT; c++) begin
      if (inject && c == 30) start = 1'b1;   // R7
      if (inject && c == 31) start = 1'b0;
      @(negedge clk);
      if (c == LAT - 1) chk(req, "done early", 32'(done), 32'd0);
    end
    chk(req, "done at latency (R3)", 32'(done), 32'd1);
    chk(req, "busy cleared (R3)", 32'(busy), 32'd0);
    chk(req, "x_out (R4)", 32'(x_out), 32'(ex));
    chk(req, "y_out (R4)", 32'(y_out), 32'(ey));
    chk(req, "z_out (R4)", 32'(z_out), 32'(ez));
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    chk("R1", "done in reset", 32'(done), 32'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "busy after reset", 32'(busy), 32'd0);
    chk("R1", "outputs after reset", {8'd0, x_out[7:0], y_out[7:0], z_out[7:0]}, 32'd0);
    chk("R1", "x_out after reset", 32'(x_out), 32'd0);
  endtask

  task automatic t_basic;       // R4 R6: positive quadrant rotation
    run_op("R4", 16'h2000, 16'h0000, 16'd4096, 1'b0);
  endtask

  task automatic t_negative;    // R5: negative operands, sign-extended taps
    run_op("R5", 16'hd120, 16'hec78, 16'he890, 1'b0);
  endtask

  task automatic t_zero_angle;  // R9
    run_op("R9", 16'h1800, 16'hf400, 16'h0000, 1'b0);
  endtask

  task automatic t_wrap;        // R4 wrap-around with large magnitudes, R6 constants
    run_op("R6", 16'h7fff, 16'h7000, 16'h2a00, 1'b0);
  endtask

  task automatic t_ignore;      // R7
    run_op("R7", 16'h0c00, 16'h0400, 16'hf000, 1'b1);
  endtask

  task automatic t_hold;        // R8
    logic [15:0] hx, hy, hz;
    hx = x_out; hy = y_out; hz = z_out;
    x_in = 16'h7777; y_in = 16'h3333; z_in = 16'h0123;
    repeat (20) @(negedge clk);
    chk("R8", "done stays low", 32'(done), 32'd0);
    chk("R8", "x_out held", 32'(x_out), 32'(hx));
    chk("R8", "y_out held", 32'(y_out), 32'(hy));
    chk("R8", "z_out held", 32'(z_out), 32'(hz));
  endtask

  task automatic t_back_to_back; // R10: start on cycle right after done
    run_op("R10", 16'h1000, 16'h1000, 16'h1400, 1'b0);
    run_op("R10", 16'hf000, 16'h0800, 16'hec00, 1'b0);
  endtask

  initial begin
    t_reset();
    t_basic();
    t_hold();
    t_negative();
    t_zero_angle();
    t_wrap();
    t_ignore();
    t_back_to_back();
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule